// File: doc/BRIEF.md
# Timer Compare Output with Shadow Latch

This block drives one output pin from a free-running timer. Software never writes the pin directly. A write places the wanted next level into a shadow latch. When the registered timer value equals the registered compare value, the shadow level is copied into the port latch, and the port latch drives the pin. Software can therefore schedule a rising edge, a falling edge, or no edge at all for an exact timer count. The CPU's own timing does not move the edge.

The match signal stays high for as long as the timer and compare values are equal. With a slowly ticking timer this can last many clock cycles. For that whole interval the two latches act as one transparent latch: a CPU write lands in both of them at the same clock edge.

Two read paths exist. A read-modify-write access sees the shadow latch. A plain read sees the pin level.

Top module: `cmp_shadow_out`

## Requirements
- R1: A synchronous active-high reset sets the shadow latch and the port latch to 1, and clears both the compare register and the timer register to 0. After reset, `pin` reads 1 and `hit` reads 1.
- R2: `hit` is 1 exactly when the registered timer value equals the registered compare value. It follows that equality combinationally.
- R3: The timer register takes `tmr_val` on an edge where `tmr_tick` is 1. It keeps its value on any other edge. With neither `tmr_tick` nor `cmp_load` asserted, `hit` does not change.
- R4: A value presented on `cmp_val` with `cmp_load` at 1 is used for comparison from the cycle after the load edge.
- R5: A write (`wr_en`=1) stores `wr_lvl` into the shadow latch. If `hit` is 0 in that cycle, the pin is unchanged. With `wr_en` at 0 the shadow latch holds its value.
- R6: At an edge where `hit` is 1 and no write occurs, the port latch takes the shadow value. The pin toggles only if the two values differ, so both rising and falling edges can be scheduled.
- R7: At an edge where `hit` is 1 and `wr_en` is 1, the shadow latch and the port latch both take `wr_lvl`. The newly written level wins over the old shadow value.
- R8: Over a run of cycles in which `hit` stays at 1, the pin follows every write one cycle later.
- R9: `rd_data` equals the shadow latch when `rmw` is 1 and the pin level when `rmw` is 0.
- R10: A write made with `rmw` at 1 stores into the shadow latch exactly like a plain write.
- R11: At an edge where `hit` is 0, the pin keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single synchronous clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_val | input | TW | Current timer count |
| tmr_tick | input | 1 | Timer register captures `tmr_val` when high |
| cmp_val | input | TW | New compare value |
| cmp_load | input | 1 | Compare register load strobe |
| wr_en | input | 1 | CPU write strobe into the shadow latch |
| wr_lvl | input | 1 | Level written by the CPU |
| rmw | input | 1 | Read-modify-write qualifier; selects the shadow latch for `rd_data` |
| rd_data | output | 1 | Read data: shadow latch or pin level |
| hit | output | 1 | Compare match (timer equals compare) |
| pin | output | 1 | Compare output pin, driven by the port latch |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset is held for at least one edge before use. The stability check on `hit` also assumes the timer register moves only through `tmr_tick`. The bench changes inputs only on the falling clock edge, holds reset for two edges, and never drives X. It runs a narrow 4-bit timer so that every timer and compare pair can be swept. It then walks every combination of shadow level, port level, match state, write strobe, write level and read qualifier.

// File: rtl/csh_pkg.sv
`timescale 1ns/1ps
package csh_pkg;

    // One CPU-side write request into the channel.
    typedef struct packed {
        logic en;
        logic lvl;
    } cpu_wr_t;

    // Two-stage output state: software-owned shadow and pin-driving port.
    typedef struct packed {
        logic shadow;
        logic port;
    } latch_pair_t;

    localparam latch_pair_t LATCH_RST = '{shadow: 1'b1, port: 1'b1};

    // Next state of the latch pair. While the match is active the pair is
    // transparent, so a write in the same cycle reaches the port as well.
    function automatic latch_pair_t latch_next(latch_pair_t cur, cpu_wr_t wr, logic hit);
        latch_pair_t nx;
        nx.shadow = wr.en ? wr.lvl : cur.shadow;
        nx.port   = hit ? nx.shadow : cur.port;
        return nx;
    endfunction

    // Read path: the read-modify-write qualifier sees the shadow,
    // an ordinary read sees the pin.
    function automatic logic rd_pick(latch_pair_t cur, logic use_shadow);
        return use_shadow ? cur.shadow : cur.port;
    endfunction

endpackage

// File: rtl/csh_hold_reg.sv
`timescale 1ns/1ps
module csh_hold_reg #(
    parameter int         W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/csh_eq_cmp.sv
`timescale 1ns/1ps
module csh_eq_cmp #(
    parameter int W       = 16,
    parameter int SLICE_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);

    localparam int NSL = (W + SLICE_W - 1) / SLICE_W;
    localparam int PW  = NSL * SLICE_W;

    logic [PW-1:0]  a_pad;
    logic [PW-1:0]  b_pad;
    logic [NSL-1:0] slice_eq;

    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[W-1:0] = a;
        b_pad[W-1:0] = b;
    end

    // Slice-wise equality, then a reduction tree across slices.
    for (genvar g = 0; g < NSL; g++) begin : g_slice
        assign slice_eq[g] = (a_pad[g*SLICE_W +: SLICE_W] == b_pad[g*SLICE_W +: SLICE_W]);
    end

    assign eq = &slice_eq;

endmodule

// File: rtl/csh_latch_pair.sv
`timescale 1ns/1ps
module csh_latch_pair
    import csh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cpu_wr_t     wr,
    input  logic        hit,
    output latch_pair_t st
);

    latch_pair_t st_nx;

    always_comb begin
        st_nx = latch_next(st, wr, hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= LATCH_RST;
        end else begin
            st <= st_nx;
        end
    end

endmodule

// File: rtl/cmp_shadow_out.sv
`timescale 1ns/1ps
module cmp_shadow_out
    import csh_pkg::*;
#(
    parameter int TW      = 16,
    parameter int SLICE_W = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tmr_val,
    input  logic          tmr_tick,
    input  logic [TW-1:0] cmp_val,
    input  logic          cmp_load,
    input  logic          wr_en,
    input  logic          wr_lvl,
    input  logic          rmw,
    output logic          rd_data,
    output logic          hit,
    output logic          pin
);

    logic [TW-1:0] tmr_q;
    logic [TW-1:0] cmp_q;
    cpu_wr_t       wr_req;
    latch_pair_t   lp;
    logic          shadow_lvl;

    csh_hold_reg #(.W(TW), .RST_VAL('0)) u_tmr (
        .clk (clk),
        .rst (rst),
        .ld  (tmr_tick),
        .d   (tmr_val),
        .q   (tmr_q)
    );

    csh_hold_reg #(.W(TW), .RST_VAL('0)) u_cmp (
        .clk (clk),
        .rst (rst),
        .ld  (cmp_load),
        .d   (cmp_val),
        .q   (cmp_q)
    );

    csh_eq_cmp #(.W(TW), .SLICE_W(SLICE_W)) u_eq (
        .a  (tmr_q),
        .b  (cmp_q),
        .eq (hit)
    );

    assign wr_req = '{en: wr_en, lvl: wr_lvl};

    csh_latch_pair u_lp (
        .clk (clk),
        .rst (rst),
        .wr  (wr_req),
        .hit (hit),
        .st  (lp)
    );

    assign shadow_lvl = lp.shadow;
    assign pin        = lp.port;
    assign rd_data    = rd_pick(lp, rmw);

endmodule

// File: rtl/csh_chk.sv
`timescale 1ns/1ps
module csh_chk (
    input logic clk,
    input logic rst,
    input logic tmr_tick,
    input logic cmp_load,
    input logic wr_en,
    input logic wr_lvl,
    input logic hit,
    input logic pin,
    input logic shadow_lvl
);

    AST_RST_STATE: assert property (@(posedge clk) rst |=> (pin && shadow_lvl)); // R1
    AST_HIT_STABLE: assert property (@(posedge clk) disable iff (rst) (!tmr_tick && !cmp_load) |=> $stable(hit)); // R3
    AST_SHADOW_WR: assert property (@(posedge clk) disable iff (rst) wr_en |=> (shadow_lvl == $past(wr_lvl))); // R5
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(shadow_lvl)); // R5
    AST_HIT_COPY: assert property (@(posedge clk) disable iff (rst) (hit && !wr_en) |=> (pin == $past(shadow_lvl))); // R6
    AST_HIT_WRITE: assert property (@(posedge clk) disable iff (rst) (hit && wr_en) |=> (pin == $past(wr_lvl))); // R7
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst) !hit |=> $stable(pin)); // R11

endmodule

bind cmp_shadow_out csh_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tmr_tick   (tmr_tick),
    .cmp_load   (cmp_load),
    .wr_en      (wr_en),
    .wr_lvl     (wr_lvl),
    .hit        (hit),
    .pin        (pin),
    .shadow_lvl (shadow_lvl)
);

// File: tb/cmp_shadow_out_test.sv
`timescale 1ns/1ps
module cmp_shadow_out_test;

    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] tmr_val = '0;
    logic          tmr_tick = 1'b0;
    logic [TW-1:0] cmp_val = '0;
    logic          cmp_load = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_lvl = 1'b0;
    logic          rmw = 1'b0;
    logic          rd_data;
    logic          hit;
    logic          pin;

    int n_run  = 0;
    int n_fail = 0;

    // Reference state, kept from the requirements.
    int m_t  = 0;
    int m_c  = 0;
    int m_sh = 1;
    int m_pt = 1;

    cmp_shadow_out #(.TW(TW), .SLICE_W(2)) uut (
        .clk      (clk),
        .rst      (rst),
        .tmr_val  (tmr_val),
        .tmr_tick (tmr_tick),
        .cmp_val  (cmp_val),
        .cmp_load (cmp_load),
        .wr_en    (wr_en),
        .wr_lvl   (wr_lvl),
        .rmw      (rmw),
        .rd_data  (rd_data),
        .hit      (hit),
        .pin      (pin)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive on the falling edge, update the reference at the
    // rising edge, compare shortly after it.
    task automatic step(input int tk, input int tv, input int ld, input int cv,
                        input int we, input int wl, input int rs);
        int    old_hit;
        int    nsh;
        string pin_req;
        string hit_req;
        @(negedge clk);
        tmr_tick = tk[0];
        tmr_val  = TW'(tv);
        cmp_load = ld[0];
        cmp_val  = TW'(cv);
        wr_en    = we[0];
        wr_lvl   = wl[0];
        rmw      = rs[0];
        @(posedge clk);
        old_hit = (m_t == m_c) ? 1 : 0;
        nsh     = we ? wl : m_sh;
        if (old_hit != 0) m_pt = nsh;
        m_sh = nsh;
        if (tk != 0) m_t = tv;
        if (ld != 0) m_c = cv;
        if (old_hit != 0 && we != 0)      pin_req = "R7/R8";
        else if (old_hit != 0)            pin_req = "R6";
        else if (we != 0)                 pin_req = "R5";
        else                              pin_req = "R11";
        if (ld != 0)                      hit_req = "R4";
        else if (tk == 0)                 hit_req = "R3";
        else                              hit_req = "R2";
        #1;
        check(int'(pin) == m_pt, pin_req, int'(pin), m_pt);
        check(int'(hit) == ((m_t == m_c) ? 1 : 0), hit_req, int'(hit), (m_t == m_c) ? 1 : 0);
        if (rs != 0)
            check(int'(rd_data) == m_sh, (we != 0) ? "R10" : "R9", int'(rd_data), m_sh);
        else
            check(int'(rd_data) == m_pt, "R9", int'(rd_data), m_pt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rmw = 1'b1;
        #1;
        // R1: reset state
        check(pin == 1'b1, "R1", int'(pin), 1);
        check(hit == 1'b1, "R1", int'(hit), 1);
        check(rd_data == 1'b1, "R1", int'(rd_data), 1);

        // R2/R3/R4: all compare and timer pairs, plus held-timer cycles
        for (int c = 0; c < (1 << TW); c++) begin
            step(0, 0, 1, c, 0, 0, 0);
            for (int t = 0; t < (1 << TW); t++) begin
                step(1, t, 0, 0, 0, 0, t & 1);
                step(0, (t + 3) % (1 << TW), 0, 0, 0, 0, 0);
            end
        end

        // R5..R11: every shadow, port, match, write, level, qualifier combination
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 2; p++)
                for (int h = 0; h < 2; h++)
                    for (int w = 0; w < 2; w++)
                        for (int l = 0; l < 2; l++)
                            for (int r = 0; r < 2; r++) begin
                                step(1, 5, 1, 5, 0, 0, 0);
                                step(0, 0, 0, 0, 1, p, 0);
                                step(0, 0, 1, 9, 0, 0, 0);
                                step(0, 0, 0, 0, 1, s, 1);
                                if (h != 0) step(0, 0, 1, 5, 0, 0, 0);
                                step(0, 0, 0, 0, w, l, r);
                            end

        // R8: a long match with a stalled timer, writes alternate each cycle
        step(1, 7, 1, 7, 0, 0, 0);
        for (int k = 0; k < 8; k++) begin
            step(0, 0, 0, 0, 1, k & 1, k & 2);
        end
        // leave the match, then writes must not reach the pin (R5/R11)
        step(1, 8, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 0, 0, 1, (k + 1) & 1, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule